// File: doc/BRIEF.md
# Nibble Accumulator ALU with Persistent Carry

This block is the arithmetic heart of a small 4-bit processor. It holds a 4-bit accumulator and a single carry flip-flop. On each execute step it takes one 4-bit operand, delivered by the read port of a sixteen-entry register array, and combines it with the accumulator under a 3-bit operation code. The available operations are:

- add with carry
- subtract by complement-and-add
- bitwise AND
- bitwise OR
- plain transfer of the operand
- clear carry
- set carry

The accumulator and the carry change only on a rising clock edge, and only when the execute strobe is high. The carry survives from one step to the next, so a sequence of add steps over successive nibbles forms a wider sum. The controller that sequences such a chain first sets the carry to a known value with the clear-carry or set-carry code. Instruction decoding, the register array itself and any bus steering stay outside the block.

Top module: `nibble_accum_alu`

## Requirements
- R1: While `rst` is high at a rising clock edge, `acc_q` becomes 0 and `carry_q` becomes 0, whatever the other inputs are.
- R2: At an edge where `exec_en` is low, `acc_q` and `carry_q` keep their values.
- R3: Code 3'b001 (add): `{carry_q, acc_q}` becomes the 5-bit value `acc_q + operand + carry_q`.
- R4: Code 3'b010 (subtract): `{carry_q, acc_q}` becomes the 5-bit value `acc_q + (~operand & 4'hF) + (carry_q ? 0 : 1)`. A carry of 1 afterwards means no borrow occurred.
- R5: Code 3'b011 loads `acc_q & operand` and code 3'b100 loads `acc_q | operand`. Both leave `carry_q` unchanged.
- R6: Code 3'b000 (transfer) loads `operand` into `acc_q` and leaves `carry_q` unchanged.
- R7: Code 3'b101 clears `carry_q` and code 3'b110 sets `carry_q`. Both leave `acc_q` unchanged.
- R8: Code 3'b111 changes neither `acc_q` nor `carry_q`.
- R9: The carry written by one add step is the carry-in of the next. Two add steps, low nibble first after a clear-carry, give the correct 8-bit sum, with the final carry as bit 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| exec_en | input | 1 | Execute strobe; state updates only when high |
| op_sel | input | 3 | Operation code (see R3 to R8) |
| operand | input | 4 | Operand from the register-array read port |
| acc_q | output | 4 | Accumulator |
| carry_q | output | 1 | Carry flip-flop |

## Verification
The bench uses the default width of 4 bits. At this width the full operand space of 16 values, times the 16 accumulator values and both carry states, is small. A few thousand random steps therefore reach every add and subtract overflow and borrow pattern many times. Directed cases pin down the 4'hF + 1 wrap, the 0 - 1 borrow, the carry-in variants of subtract and a two-nibble chained sum.

// File: rtl/nalu_pkg.sv
package nalu_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [2:0] {
        OP_MOVE = 3'd0,
        OP_ADD  = 3'd1,
        OP_SUB  = 3'd2,
        OP_AND  = 3'd3,
        OP_OR   = 3'd4,
        OP_CLRC = 3'd5,
        OP_SETC = 3'd6,
        OP_NOP  = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        RES_SUM  = 2'd0,
        RES_AND  = 2'd1,
        RES_OR   = 2'd2,
        RES_OPND = 2'd3
    } res_sel_e;

    typedef enum logic [1:0] {
        CYS_ADDER = 2'd0,
        CYS_ZERO  = 2'd1,
        CYS_ONE   = 2'd2
    } cy_sel_e;

    typedef struct packed {
        logic     acc_we;
        logic     cy_we;
        logic     sub;
        res_sel_e res_sel;
        cy_sel_e  cy_sel;
    } alu_ctl_t;

    function automatic alu_ctl_t decode_op(alu_op_e op);
        alu_ctl_t c;
        c = '{acc_we: 1'b0, cy_we: 1'b0, sub: 1'b0,
              res_sel: RES_SUM, cy_sel: CYS_ADDER};
        case (op)
            OP_MOVE: begin c.acc_we = 1'b1; c.res_sel = RES_OPND; end
            OP_ADD:  begin c.acc_we = 1'b1; c.cy_we = 1'b1; end
            OP_SUB:  begin c.acc_we = 1'b1; c.cy_we = 1'b1; c.sub = 1'b1; end
            OP_AND:  begin c.acc_we = 1'b1; c.res_sel = RES_AND; end
            OP_OR:   begin c.acc_we = 1'b1; c.res_sel = RES_OR; end
            OP_CLRC: begin c.cy_we = 1'b1; c.cy_sel = CYS_ZERO; end
            OP_SETC: begin c.cy_we = 1'b1; c.cy_sel = CYS_ONE; end
            default: c = c;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/nalu_decode.sv
module nalu_decode
    import nalu_pkg::*;
(
    input  logic [2:0] op_code,
    output alu_ctl_t   ctl
);
    always_comb ctl = decode_op(alu_op_e'(op_code));
endmodule

// File: rtl/nalu_adder.sv
module nalu_adder #(
    parameter int W = nalu_pkg::NIB_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W-1:0] b_eff;
    logic [W:0]   c;

    assign b_eff = sub ? ~b : b;
    assign c[0]  = sub ? ~cin : cin;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum[i]  = a[i] ^ b_eff[i] ^ c[i];
        assign c[i+1]  = (a[i] & b_eff[i]) | (c[i] & (a[i] ^ b_eff[i]));
    end

    assign cout = c[W];
endmodule

// File: rtl/nalu_state.sv
module nalu_state #(
    parameter int W = nalu_pkg::NIB_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         exec_en,
    input  logic         acc_we,
    input  logic         cy_we,
    input  logic [W-1:0] acc_d,
    input  logic         cy_d,
    output logic [W-1:0] acc_q,
    output logic         cy_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            cy_q  <= 1'b0;
        end else if (exec_en) begin
            if (acc_we) acc_q <= acc_d;
            if (cy_we)  cy_q  <= cy_d;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (acc_q == '0) && !cy_q);

    a_r2_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !exec_en |=> $stable(acc_q) && $stable(cy_q));
endmodule

// File: rtl/nibble_accum_alu.sv
module nibble_accum_alu
    import nalu_pkg::*;
#(
    parameter int W = NIB_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         exec_en,
    input  logic [2:0]   op_sel,
    input  logic [W-1:0] operand,
    output logic [W-1:0] acc_q,
    output logic         carry_q
);
    localparam int SW = W + 1;

    alu_ctl_t     ctl;
    logic [W-1:0] sum;
    logic         cout;
    logic [W-1:0] acc_d;
    logic         cy_d;

    nalu_decode u_dec (
        .op_code (op_sel),
        .ctl     (ctl)
    );

    nalu_adder #(.W(W)) u_add (
        .a    (acc_q),
        .b    (operand),
        .cin  (carry_q),
        .sub  (ctl.sub),
        .sum  (sum),
        .cout (cout)
    );

    always_comb begin
        case (ctl.res_sel)
            RES_SUM:  acc_d = sum;
            RES_AND:  acc_d = acc_q & operand;
            RES_OR:   acc_d = acc_q | operand;
            default:  acc_d = operand;
        endcase
        case (ctl.cy_sel)
            CYS_ZERO: cy_d = 1'b0;
            CYS_ONE:  cy_d = 1'b1;
            default:  cy_d = cout;
        endcase
    end

    nalu_state #(.W(W)) u_st (
        .clk     (clk),
        .rst     (rst),
        .exec_en (exec_en),
        .acc_we  (ctl.acc_we),
        .cy_we   (ctl.cy_we),
        .acc_d   (acc_d),
        .cy_d    (cy_d),
        .acc_q   (acc_q),
        .cy_q    (carry_q)
    );

    logic [W-1:0] opnd_inv;
    assign opnd_inv = ~operand;

    a_r3_add_sum: assert property (@(posedge clk) disable iff (rst)
        exec_en && op_sel == OP_ADD |=>
        {carry_q, acc_q} == SW'($past(acc_q)) + SW'($past(operand)) + SW'($past(carry_q)));

    a_r4_sub_sum: assert property (@(posedge clk) disable iff (rst)
        exec_en && op_sel == OP_SUB |=>
        {carry_q, acc_q} == SW'($past(acc_q)) + SW'($past(opnd_inv)) + SW'(!$past(carry_q)));

    a_r5_logic_keeps_carry: assert property (@(posedge clk) disable iff (rst)
        exec_en && (op_sel == OP_AND || op_sel == OP_OR) |=> $stable(carry_q));

    a_r6_move_loads: assert property (@(posedge clk) disable iff (rst)
        exec_en && op_sel == OP_MOVE |=> acc_q == $past(operand) && $stable(carry_q));

    a_r7_clr_carry: assert property (@(posedge clk) disable iff (rst)
        exec_en && op_sel == OP_CLRC |=> !carry_q && $stable(acc_q));

    a_r7_set_carry: assert property (@(posedge clk) disable iff (rst)
        exec_en && op_sel == OP_SETC |=> carry_q && $stable(acc_q));

    a_r8_nop_idle: assert property (@(posedge clk) disable iff (rst)
        exec_en && op_sel == OP_NOP |=> $stable(acc_q) && $stable(carry_q));
endmodule

// File: tb/tb_nibble_accum_alu.sv
module tb_nibble_accum_alu;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         exec_en = 1'b0;
    logic [2:0]   op_sel = 3'd7;
    logic [W-1:0] operand = '0;
    logic [W-1:0] acc_q;
    logic         carry_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [W-1:0] m_acc = '0;
    logic         m_cy  = 1'b0;

    always #5 clk = ~clk;

    nibble_accum_alu #(.W(W)) dut (
        .clk(clk), .rst(rst), .exec_en(exec_en), .op_sel(op_sel),
        .operand(operand), .acc_q(acc_q), .carry_q(carry_q)
    );

    function automatic string tag_of(bit en, logic [2:0] op);
        if (!en) return "R2";
        case (op)
            3'd0: return "R6";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3, 3'd4: return "R5";
            3'd5, 3'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic model(bit en, logic [2:0] op, logic [W-1:0] b);
        logic [W:0] s;
        if (!en) return;
        case (op)
            3'd0: m_acc = b;
            3'd1: begin s = {1'b0, m_acc} + {1'b0, b} + {{W{1'b0}}, m_cy};
                  m_acc = s[W-1:0]; m_cy = s[W]; end
            3'd2: begin s = {1'b0, m_acc} + {1'b0, ~b} + {{W{1'b0}}, ~m_cy};
                  m_acc = s[W-1:0]; m_cy = s[W]; end
            3'd3: m_acc = m_acc & b;
            3'd4: m_acc = m_acc | b;
            3'd5: m_cy = 1'b0;
            3'd6: m_cy = 1'b1;
            default: ;
        endcase
    endtask

    task automatic check(string tag);
        n_chk++;
        if (acc_q !== m_acc || carry_q !== m_cy) begin
            n_bad++;
            $display("FAIL %s: acc=%h carry=%b expected acc=%h carry=%b",
                     tag, acc_q, carry_q, m_acc, m_cy);
        end
    endtask

    // drive at negedge, edge in between, compare at next negedge
    task automatic step(bit en, logic [2:0] op, logic [W-1:0] b, string tag = "");
        exec_en = en; op_sel = op; operand = b;
        @(negedge clk);
        model(en, op, b);
        check(tag == "" ? tag_of(en, op) : tag);
    endtask

    initial begin
        int seed;
        seed = 32'h1a2b;
        void'($urandom(seed));
        @(negedge clk);
        rst = 1'b1; exec_en = 1'b1; op_sel = 3'd6; operand = 4'h9;
        @(negedge clk);
        @(negedge clk);
        m_acc = '0; m_cy = 1'b0;
        check("R1");
        rst = 1'b0;

        // R3 wrap: F + 1 with carry 0
        step(1, 3'd0, 4'hF);
        step(1, 3'd5, 4'h0);
        step(1, 3'd1, 4'h1, "R3");
        step(1, 3'd1, 4'hF, "R3");
        // R4 borrow: 0 - 1, carry 0 -> F, carry 0
        step(1, 3'd0, 4'h0);
        step(1, 3'd5, 4'h0);
        step(1, 3'd2, 4'h1, "R4");
        // R4 with carry set: 7 - 2 - 1 = 4, no borrow
        step(1, 3'd0, 4'h7);
        step(1, 3'd6, 4'h0);
        step(1, 3'd2, 4'h2, "R4");
        // R5/R6 keep carry set
        step(1, 3'd6, 4'h0);
        step(1, 3'd3, 4'h5, "R5");
        step(1, 3'd4, 4'hA, "R5");
        step(1, 3'd0, 4'h3, "R6");
        // R7, R8, R2
        step(1, 3'd5, 4'hC, "R7");
        step(1, 3'd7, 4'hC, "R8");
        step(0, 3'd0, 4'hE, "R2");
        step(0, 3'd6, 4'hE, "R2");

        // R9: 8-bit chained sums
        for (int k = 0; k < 40; k++) begin
            logic [7:0] x, y;
            logic [8:0] ref_sum;
            logic [W-1:0] lo;
            x = 8'($urandom); y = 8'($urandom);
            if (k == 0) begin x = 8'hFF; y = 8'h01; end
            ref_sum = {1'b0, x} + {1'b0, y};
            step(1, 3'd5, 4'h0);
            step(1, 3'd0, x[3:0]);
            step(1, 3'd1, y[3:0], "R9");
            lo = acc_q;
            step(1, 3'd0, x[7:4]);
            step(1, 3'd1, y[7:4], "R9");
            n_chk++;
            if ({carry_q, acc_q, lo} !== ref_sum) begin
                n_bad++;
                $display("FAIL R9: sum=%h expected %h", {carry_q, acc_q, lo}, ref_sum);
            end
        end

        // random mix
        for (int k = 0; k < 3000; k++) begin
            bit en;
            en = ($urandom % 8) != 0;
            step(en, 3'($urandom), 4'($urandom));
        end

        // mid-run reset
        rst = 1'b1;
        @(negedge clk);
        m_acc = '0; m_cy = 1'b0;
        check("R1");
        rst = 1'b0;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule